// File: doc/BRIEF.md
# Reordered Decade Counter with Illegal-Code Recovery

This block is a 4-bit synchronous counter that does not count in binary. While its count-enable is high it visits nine codes in a fixed order: the even values 0, 2, 4, 6 and 8, then the odd values 1, 3, 5 and 9, and then it returns to 0. The state is held in four toggle flip-flops. Each flip-flop has its own toggle enable, and that enable is decoded from the present state. A bit toggles only when it differs between the present code and the code that follows it.

The codes 7 and 10 to 15 are outside the order. If the register ever holds one of them, because of an upset or a fault at power-up, the next enabled clock edge returns it to 0. A synchronous reset also clears the count. When the count-enable input is low, the count holds its value. The pins are plain control pins with no handshake, since no data stream enters or leaves the block.

Top module: `reorder_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` becomes 0 after that edge, whatever the value of `cnt_en`.
- R2: With `cnt_en` high at every edge, starting from 0, `count` takes the values 2, 4, 6, 8, 1, 3, 5, 9 on successive edges.
- R3: From 9, one enabled edge moves `count` to 0, so the order repeats with a period of nine edges.
- R4: From any of the codes 10, 11, 12, 13, 14 or 15, exactly one enabled edge moves `count` to 0.
- R5: Code 7 is treated as illegal: one enabled edge moves it to 0.
- R6: While `cnt_en` is low and `rst` is low, `count` keeps its value across edges, including partway through the order.
- R7: `rst` takes priority over `cnt_en`: a reset in the middle of the order returns `count` to 0, and counting then resumes from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; when low, all toggle enables are held low |
| count | output | 4 | Present code, bit 3 is the most significant |

## Verification
The assertions assume that `rst` and `cnt_en` are settled at each rising edge and that reset is high at the first edge, so `count` is defined before any property that uses `$stable` or compares a value one edge later. The illegal codes cannot be reached through the ports. The bench therefore places them in the state register between edges, with `cnt_en` already high for at least one edge before. This keeps the hold property from seeing a change that the counter did not make itself. All other stimulus changes the inputs only on the falling edge.

// File: rtl/reorder_counter_pkg.sv
package reorder_counter_pkg;

  localparam int CNT_W = 4;

  typedef logic [CNT_W-1:0] code_t;

  // Successor of each code in the counting order; unused codes map to zero.
  function automatic code_t successor(input code_t cur);
    code_t nxt;
    unique case (cur)
      4'd0:    nxt = 4'd2;
      4'd2:    nxt = 4'd4;
      4'd4:    nxt = 4'd6;
      4'd6:    nxt = 4'd8;
      4'd8:    nxt = 4'd1;
      4'd1:    nxt = 4'd3;
      4'd3:    nxt = 4'd5;
      4'd5:    nxt = 4'd9;
      4'd9:    nxt = 4'd0;
      default: nxt = 4'd0;
    endcase
    return nxt;
  endfunction

  function automatic logic is_legal(input code_t cur);
    return (cur <= 4'd9) && (cur != 4'd7);
  endfunction

endpackage

// File: rtl/reorder_next_map.sv
module reorder_next_map
  import reorder_counter_pkg::*;
(
  input  code_t cur,
  output code_t nxt
);

  always_comb begin
    nxt = successor(cur);
  end

endmodule

// File: rtl/reorder_toggle_gen.sv
module reorder_toggle_gen #(
  parameter int W = 4
) (
  input  logic         en,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] tog
);

  // One enable per flip-flop: set where present and next codes disagree.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign tog[i] = en & (cur[i] ^ nxt[i]);
  end

endmodule

// File: rtl/reorder_tff_bank.sv
module reorder_tff_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tog,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= q_r ^ tog;
  end

  assign q = q_r;

endmodule

// File: rtl/reorder_counter.sv
module reorder_counter
  import reorder_counter_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] count
);

  code_t cur_code;
  code_t nxt_code;
  logic [CNT_W-1:0] tog;

  reorder_next_map u_map (
    .cur (cur_code),
    .nxt (nxt_code)
  );

  reorder_toggle_gen #(.W(CNT_W)) u_tog (
    .en  (cnt_en),
    .cur (cur_code),
    .nxt (nxt_code),
    .tog (tog)
  );

  reorder_tff_bank #(.W(CNT_W)) u_bank (
    .clk (clk),
    .rst (rst),
    .tog (tog),
    .q   (cur_code)
  );

  assign count = cur_code;

  assert_sync_reset_R1: assert property (@(posedge clk)
    rst |=> (count == 4'd0));

  assert_odd_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == 4'd8) |=> (count == 4'd1));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == 4'd9) |=> (count == 4'd0));

  assert_recover_high_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count >= 4'd10) |=> (count == 4'd0));

  assert_recover_seven_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == 4'd7) |=> (count == 4'd0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count));

endmodule

// File: tb/sim_reorder_counter.sv
module sim_reorder_counter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic [3:0] count;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int order [9] = '{0, 2, 4, 6, 8, 1, 3, 5, 9};

  always #4 clk = ~clk;

  reorder_counter u0 (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .count  (count)
  );

  task automatic check(input string req, input int exp);
    n_cmp++;
    if (count !== 4'(exp)) begin
      n_bad++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; cnt_en = 1'b1;
    edge_step();
    check("R1", 0);
    rst = 1'b0;
  endtask

  task automatic t_order();
    rst = 1'b0; cnt_en = 1'b1;
    for (int lap = 0; lap < 2; lap++) begin
      for (int k = 1; k < 9; k++) begin
        edge_step();
        check("R2", order[k]);
      end
      edge_step();
      check("R3", 0);
    end
  endtask

  task automatic t_hold();
    cnt_en = 1'b1;
    edge_step(); edge_step(); edge_step(); edge_step(); edge_step();
    check("R2", 1);
    cnt_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      edge_step();
      check("R6", 1);
    end
    cnt_en = 1'b1;
    edge_step();
    check("R6", 3);
  endtask

  task automatic t_illegal(input int code);
    cnt_en = 1'b1;
    edge_step();
    force u0.u_bank.q_r = 4'(code);
    #1 release u0.u_bank.q_r;
    check(code == 7 ? "R5" : "R4", code);
    edge_step();
    check(code == 7 ? "R5" : "R4", 0);
    edge_step();
    check(code == 7 ? "R5" : "R4", 2);
  endtask

  task automatic t_reset_mid();
    cnt_en = 1'b1;
    edge_step(); edge_step(); edge_step();
    rst = 1'b1;
    edge_step();
    check("R7", 0);
    rst = 1'b0;
    edge_step();
    check("R7", 2);
    cnt_en = 1'b0; rst = 1'b1;
    edge_step();
    check("R7", 0);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_hold();
    t_illegal(7);
    for (int c = 10; c < 16; c++) t_illegal(c);
    t_reset_mid();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: count=%0d expected=finish", count);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule